// File: doc/BRIEF.md
# Synchronous Card Activation Sequencer

This block powers up a synchronous memory card in a user card slot and reads the card's 32-bit answer. A start command is accepted only while the card-type setting selects synchronous cards and the activation-type setting selects the first of the two synchronous sequences. The block then turns on the card supply and waits for a supply-good indication. Once the supply is good it pulls the data line up and drives the two auxiliary contacts from their configuration bits. It then produces a single reset pulse with one short clock pulse nested inside it.

After a fixed low gap, the block drives reset low and runs the card clock for exactly 32 periods of 25 µs. On each of the 32 edges of the chosen polarity it shifts the card data line into a capture register. At the end of the 32nd period it hands the card clock and reset pins to the host's normal register settings. If routing is enabled it connects the data line to the host data path. It then sets a completion flag, which drives an active-low interrupt until the host clears the flag with a write-one-to-clear strobe.

All intervals are counted in half-microsecond ticks taken from the system clock. The parameter `CLK_PER_US` gives the number of system clocks per microsecond and must be even. With any legal value every interval comes out at its nominal length.

Top module: `sync_card_activator`

## Requirements
- R1: After reset, card_pwr_en, card_rst, card_clk, io_pullup, aux_out and io_connect are all 0, irq_n is 1 and capture is 0.
- R2: start is accepted only in the idle state with card_sync=1 and act_type2=0. Any other start leaves card_pwr_en at 0.
- R3: After an accepted start, card_pwr_en goes to 1. card_rst, card_clk, io_pullup and aux_out stay 0 for as long as supply_good is 0.
- R4: From the first cycle after supply_good is seen, io_pullup is 1 and aux_out equals aux_cfg (bit 0 drives the first auxiliary contact, bit 1 the second).
- R5: card_rst is high for 70 µs (140 ticks). card_clk rises 28 µs (56 ticks) after card_rst rises and stays high for 12.5 µs (25 ticks).
- R6: card_rst falls 29.5 µs (59 ticks) after that clock pulse falls. card_clk then stays low for 80 µs (160 ticks) after card_rst falls.
- R7: During capture, card_rst stays 0 and card_clk runs exactly 32 periods of 25 µs (50 ticks), each high for the first 12.5 µs.
- R8: With edge_fall=0 io_in is sampled on the 32 rising edges, and with edge_fall=1 on the 32 falling edges. The first sample lands in capture bit 0 and the last in bit 31.
- R9: 25 µs after the 32nd rising edge, done_flag becomes 1 and irq_n 0. card_clk then follows host_clk, card_rst follows host_rst, and io_connect equals io_route_en. Before this point host_clk, host_rst and io_route_en have no effect.
- R10: A done_clr pulse clears done_flag and returns irq_n to 1, and capture keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start command (self-clearing register bit) |
| card_sync | input | 1 | Card-type setting, 1 = synchronous card |
| act_type2 | input | 1 | Activation-type setting, 0 = first synchronous sequence |
| edge_fall | input | 1 | Sampling edge, 0 = rising, 1 = falling |
| aux_cfg | input | 2 | Levels for the two auxiliary contacts |
| io_route_en | input | 1 | Connect the card data line to the host after completion |
| host_clk | input | 1 | Card clock level from the normal clock settings |
| host_rst | input | 1 | Card reset level from the host register |
| done_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| supply_good | input | 1 | Card supply reported stable |
| io_in | input | 1 | Card data line level |
| card_pwr_en | output | 1 | Card supply enable |
| card_rst | output | 1 | Card reset pin |
| card_clk | output | 1 | Card clock pin |
| aux_out | output | 2 | Auxiliary contact levels |
| io_pullup | output | 1 | Data line pull-up enable |
| io_connect | output | 1 | Data line connected to the host data path |
| capture | output | 32 | Captured answer, first sample in bit 0 |
| done_flag | output | 1 | Completion status flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with `CLK_PER_US=2`. At that value one half-microsecond tick equals one system clock, so every interval can be checked to the exact cycle by timing pin edges. A complete activation then takes about 2000 cycles. This short run lets the bench sweep both sampling edges, all four auxiliary settings, both routing settings and patterns that probe bit ordering (all zeros, all ones, a lone first bit, a lone last bit and a mixed word). The bench also checks that both kinds of disallowed start are ignored.

// File: rtl/sca_pkg.sv
`timescale 1ns/1ps
package sca_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PWR   = 3'd1,
    S_LEAD  = 3'd2,
    S_PULSE = 3'd3,
    S_TAIL  = 3'd4,
    S_GAP   = 3'd5,
    S_RUN   = 3'd6,
    S_DONE  = 3'd7
  } sca_state_e;

  // interval lengths in half-microsecond ticks
  localparam int LEAD_T  = 56;   // reset rise to clock rise
  localparam int PULSE_T = 25;   // first clock high
  localparam int TAIL_T  = 59;   // clock fall to reset fall
  localparam int GAP_T   = 160;  // low gap before capture clocking
  localparam int PER_T   = 50;   // capture clock period
  localparam int HIGH_T  = 25;   // capture clock high time
  localparam int NBITS   = 32;   // answer length
  localparam int CNT_W   = 8;
  localparam int BIT_W   = $clog2(NBITS);

endpackage

// File: rtl/sca_tick.sv
`timescale 1ns/1ps
module sca_tick #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int W = $clog2(DIV) + 1;
  logic [W-1:0] cnt;

  assign tick = (cnt == W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sca_seq.sv
`timescale 1ns/1ps
module sca_seq
  import sca_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  logic       supply_good,
  output sca_state_e st,
  output logic       run_hi,
  output logic       done_set
);
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bits;
  logic [CNT_W-1:0] last;
  sca_state_e       nxt_timed;

  always_comb begin
    last      = '0;
    nxt_timed = st;
    case (st)
      S_LEAD:  begin last = CNT_W'(LEAD_T - 1);  nxt_timed = S_PULSE; end
      S_PULSE: begin last = CNT_W'(PULSE_T - 1); nxt_timed = S_TAIL;  end
      S_TAIL:  begin last = CNT_W'(TAIL_T - 1);  nxt_timed = S_GAP;   end
      S_GAP:   begin last = CNT_W'(GAP_T - 1);   nxt_timed = S_RUN;   end
      S_RUN:   begin last = CNT_W'(PER_T - 1);   nxt_timed = S_RUN;   end
      default: begin last = '0;                  nxt_timed = st;      end
    endcase
  end

  assign run_hi   = (st == S_RUN) && (cnt < CNT_W'(HIGH_T));
  assign done_set = (st == S_RUN) && tick && (cnt == last) &&
                    (bits == BIT_W'(NBITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bits <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st  <= S_PWR;
          cnt <= '0;
        end
        S_PWR: if (supply_good) begin
          st  <= S_LEAD;
          cnt <= '0;
        end
        S_LEAD, S_PULSE, S_TAIL, S_GAP: if (tick) begin
          if (cnt == last) begin
            st   <= nxt_timed;
            cnt  <= '0;
            bits <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RUN: if (tick) begin
          if (cnt == last) begin
            cnt <= '0;
            if (bits == BIT_W'(NBITS - 1)) st <= S_DONE;
            else                           bits <= bits + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= st;
      endcase
    end
  end

  AST_IDLE_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !go) |=> (st == S_IDLE)); // R2
  AST_HOLD_FOR_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PWR && !supply_good) |=> (st == S_PWR)); // R3
endmodule

// File: rtl/sca_capture.sv
`timescale 1ns/1ps
module sca_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         edge_fall,
  input  logic         clk_line,
  input  logic         data_in,
  output logic [W-1:0] cap_q
);
  logic clk_d;
  logic hit;

  assign hit = en && (edge_fall ? (clk_d && !clk_line) : (!clk_d && clk_line));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0;
      cap_q <= '0;
    end else begin
      clk_d <= clk_line;
      if (clr)      cap_q <= '0;
      else if (hit) cap_q <= {data_in, cap_q[W-1:1]};
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cap_q)); // R8
endmodule

// File: rtl/sync_card_activator.sv
`timescale 1ns/1ps
module sync_card_activator
  import sca_pkg::*;
#(
  parameter int CLK_PER_US = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        card_sync,
  input  logic        act_type2,
  input  logic        edge_fall,
  input  logic [1:0]  aux_cfg,
  input  logic        io_route_en,
  input  logic        host_clk,
  input  logic        host_rst,
  input  logic        done_clr,
  input  logic        supply_good,
  input  logic        io_in,
  output logic        card_pwr_en,
  output logic        card_rst,
  output logic        card_clk,
  output logic [1:0]  aux_out,
  output logic        io_pullup,
  output logic        io_connect,
  output logic [31:0] capture,
  output logic        done_flag,
  output logic        irq_n
);
  localparam int HALF_DIV = (CLK_PER_US / 2 < 1) ? 1 : CLK_PER_US / 2;

  sca_state_e st;
  logic tick, run_hi, done_set, go, accept, after_good, in_pulse_rst;

  assign go     = start && card_sync && !act_type2;
  assign accept = go && (st == S_IDLE);

  sca_tick #(.DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(st == S_PWR), .tick(tick)
  );

  sca_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go),
    .supply_good(supply_good), .st(st), .run_hi(run_hi), .done_set(done_set)
  );

  sca_capture #(.W(NBITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(st == S_RUN),
    .edge_fall(edge_fall), .clk_line(card_clk), .data_in(io_in), .cap_q(capture)
  );

  assign after_good   = (st != S_IDLE) && (st != S_PWR);
  assign in_pulse_rst = (st == S_LEAD) || (st == S_PULSE) || (st == S_TAIL);

  assign card_pwr_en = (st != S_IDLE);
  assign io_pullup   = after_good;
  assign aux_out     = after_good ? aux_cfg : 2'b00;
  assign card_rst    = in_pulse_rst || ((st == S_DONE) && host_rst);
  assign card_clk    = (st == S_PULSE) || run_hi || ((st == S_DONE) && host_clk);
  assign io_connect  = (st == S_DONE) && io_route_en;
  assign irq_n       = !done_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_flag <= 1'b0;
    else if (done_set) done_flag <= 1'b1;
    else if (done_clr) done_flag <= 1'b0;
  end

  AST_PULLUP_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_pullup) |-> $past(supply_good)); // R4
  AST_IRQ_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(st) == S_RUN)); // R9
  AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !done_set) |=> irq_n); // R10
  AST_RUN_RST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> !card_rst); // R7
endmodule

// File: tb/sync_card_activator_tb.sv
`timescale 1ns/1ps
module sync_card_activator_tb;
  localparam longint CYC = 20;

  logic clk = 1'b0;
  logic rst_n, start, card_sync, act_type2, edge_fall, io_route_en;
  logic host_clk, host_rst, done_clr, supply_good, io_in;
  logic [1:0] aux_cfg;
  logic card_pwr_en, card_rst, card_clk, io_pullup, io_connect, done_flag, irq_n;
  logic [1:0] aux_out;
  logic [31:0] capture;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sync_card_activator #(.CLK_PER_US(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .card_sync(card_sync),
    .act_type2(act_type2), .edge_fall(edge_fall), .aux_cfg(aux_cfg),
    .io_route_en(io_route_en), .host_clk(host_clk), .host_rst(host_rst),
    .done_clr(done_clr), .supply_good(supply_good), .io_in(io_in),
    .card_pwr_en(card_pwr_en), .card_rst(card_rst), .card_clk(card_clk),
    .aux_out(aux_out), .io_pullup(io_pullup), .io_connect(io_connect),
    .capture(capture), .done_flag(done_flag), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 0; card_sync = 0; act_type2 = 0; edge_fall = 0;
    io_route_en = 0; host_clk = 0; host_rst = 0; done_clr = 0;
    supply_good = 0; io_in = 0; aux_cfg = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_seq(input logic ef, input logic [31:0] pat,
                         input logic [1:0] aux, input logic route);
    longint t0, t1, t2, t3, tr, tprev, tf, td;
    int errs;
    do_reset();
    chk("R1 idle pins", 32'({card_pwr_en, card_rst, card_clk, io_pullup, aux_out,
                             io_connect, irq_n}), 32'h01);
    chk("R1 capture", capture, 32'h0);
    edge_fall = ef; aux_cfg = aux; io_route_en = route;
    host_clk = 1'b1; host_rst = 1'b1; card_sync = 1'b1; act_type2 = 1'b0;
    io_in = pat[0];
    pulse_start();
    repeat (40) @(negedge clk);
    chk("R3 waiting for supply", 32'({card_pwr_en, card_rst, card_clk, io_pullup,
                                       aux_out, io_connect}), 32'h40);
    supply_good = 1'b1;
    wait (card_rst === 1'b1); t0 = $time;
    @(negedge clk);
    chk("R4 pullup and aux", 32'({io_pullup, aux_out}), 32'({1'b1, aux}));
    wait (card_clk === 1'b1); t1 = $time;
    wait (card_clk === 1'b0); t2 = $time;
    wait (card_rst === 1'b0); t3 = $time;
    wait (card_clk === 1'b1); tr = $time;
    chk("R5 reset to clock", 32'((t1 - t0) / CYC), 32'd56);
    chk("R5 clock pulse high", 32'((t2 - t1) / CYC), 32'd25);
    chk("R5 reset pulse", 32'((t3 - t0) / CYC), 32'd140);
    chk("R6 clock to reset fall", 32'((t2 - t0 - 81 * CYC) / CYC), 32'd0);
    chk("R6 low gap", 32'((tr - t3) / CYC), 32'd160);
    errs = 0;
    tprev = tr;
    for (int k = 0; k < 32; k++) begin
      if (k > 0) begin
        @(posedge card_clk); tr = $time;
        if (tr - tprev != 50 * CYC) errs++;
        tprev = tr;
      end
      if (ef) begin #1 io_in = pat[k]; end
      if (card_rst !== 1'b0) errs++;
      @(negedge card_clk); tf = $time;
      if (tf - tr != 25 * CYC) errs++;
      if (!ef && k < 31) begin #1 io_in = pat[k + 1]; end
    end
    chk("R7 capture clocking", 32'(errs), 32'd0);
    wait (done_flag === 1'b1); td = $time;
    chk("R9 completion time", 32'((td - tprev) / CYC), 32'd50);
    @(negedge clk);
    chk("R9 irq low", 32'(irq_n), 32'd0);
    chk("R8 answer", capture, pat);
    chk("R9 host pins", 32'({io_connect, card_clk, card_rst}), 32'({route, 2'b11}));
    host_clk = 1'b0; host_rst = 1'b0;
    @(negedge clk);
    chk("R9 host pins low", 32'({card_clk, card_rst}), 32'd0);
    @(negedge clk) done_clr = 1'b1;
    @(negedge clk) done_clr = 1'b0;
    chk("R10 cleared", 32'({done_flag, irq_n}), 32'b01);
    chk("R10 capture kept", capture, pat);
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL R7 watchdog expired: actual hang expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_0001;
    pats[3] = 32'h8000_0000; pats[4] = 32'hA5C3_1E77;

    // R2: disallowed starts are ignored
    do_reset();
    card_sync = 1'b0; supply_good = 1'b1;
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R2 async card start", 32'({card_pwr_en, card_rst}), 32'd0);
    card_sync = 1'b1; act_type2 = 1'b1;
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R2 type2 start", 32'({card_pwr_en, card_rst}), 32'd0);

    for (int e = 0; e < 2; e++)
      for (int i = 0; i < 5; i++)
        run_seq(e[0], pats[i], 2'(i + e), i[0]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule